// File: doc/BRIEF.md
# Byte/Word ROM Read Controller

This block is the read side of a small non-volatile memory that can be accessed either as 16-bit words or as 8-bit bytes. Two active-low controls must both be asserted before anything is driven. The chip enable selects the device. When it is high the device is in standby. The output enable gates the data pins. A runtime width select chooses how the array is addressed. In byte mode, an extra address line becomes the least significant byte address. That line stands in for the pin that carries the top data bit in word mode.

A high-voltage flag on an address line requests the identifier codes. Programming equipment uses these two codes to recognise the part. Each code is a single byte with odd parity, and bit 7 is the parity bit.

The data bus is modelled as a 16-bit value plus a per-bit drive enable, so high-impedance behaviour can be observed directly. Every output is registered on the clock. The array contents are a fixed function of the word address, computed at elaboration, so no file or table is needed.

Top module: `bw_rom_reader`

## Requirements
- R1: During synchronous reset (`rst_n` low at a rising edge), `dq_oe` and `dq_out` become all zero.
- R2: When `ce_n` is high (standby), `dq_oe` is all zero one cycle later, whatever the value of `oe_n`.
- R3: When `ce_n` is low and `oe_n` is high (output disable), `dq_oe` is all zero one cycle later.
- R4: The outputs change only at a rising clock edge and reflect the inputs sampled at that edge. Changing the inputs between edges leaves the outputs unchanged.
- R5: Word mode applies when `ce_n`=0, `oe_n`=0, `word_sel`=1 and no identifier request is taken. In word mode `dq_oe`=16'hFFFF and `dq_out` is the word at index `addr`. The word at index a is (a*16'h9E37 mod 2^16) XOR `ROM_SEED`, and `ROM_SEED` defaults to 16'h5A3C.
- R6: Byte mode is the same as word mode except that `word_sel`=0. In byte mode the byte address is {`addr`, `addr_lsb`}, `dq_oe`=16'h00FF, and `dq_out[15:8]` is 0. `addr_lsb`=0 puts the low half of word `addr` on `dq_out[7:0]`, and `addr_lsb`=1 puts the high half there.
- R7: An identifier read takes place when `ce_n`=0, `oe_n`=0, `id_hv`=1 and `addr[ADDR_W-1:1]` is all zero. In that case `addr[0]`=0 returns the manufacturer code 8'h01 on `dq_out[7:0]` with `dq_oe`=16'h00FF. This holds in either width mode, and `addr_lsb` is ignored.
- R8: Under the same identifier conditions, `addr[0]`=1 returns the device code 8'h9D on `dq_out[7:0]` with `dq_oe`=16'h00FF.
- R9: Every identifier byte driven on `dq_out[7:0]` has an odd number of ones, and bit 7 is the parity bit.
- R10: When `id_hv`=1 but any bit of `addr[ADDR_W-1:1]` is set, the identifier request is ignored and a normal word or byte read takes place.
- R11: Any data bit whose drive enable is 0 reads as 0 on `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; high is standby |
| oe_n | input | 1 | Output enable, active low |
| word_sel | input | 1 | 1 = 16-bit word access, 0 = 8-bit byte access |
| addr | input | ADDR_W | Word address |
| addr_lsb | input | 1 | Least significant byte address bit, used only in byte mode |
| id_hv | input | 1 | High-voltage flag requesting the identifier codes |
| dq_out | output | 16 | Registered data value |
| dq_oe | output | 16 | Registered per-bit drive enable |

## Verification
The case that is hardest to reach from the ports is the identifier read. It needs both enables low, the high-voltage flag set and every address line above bit 0 at zero, all at the same time. Random stimulus almost never lines these up. The bench therefore drives identifier reads directly, in both width modes and with `addr_lsb` toggled. It also drives the near miss in which one upper address line is set. In addition, the random phase sets the flag and clears the upper address bits more often than uniform stimulus would, so identifier reads also appear mixed in with other traffic.

// File: rtl/bw_rom_pkg.sv
// Package: shared types and the content function of the read-only array.
// Assumes a fixed 16-bit data bus split into two 8-bit lanes.
package bw_rom_pkg;
    localparam int DQ_W   = 16;
    localparam int LANE_W = DQ_W / 2;
    localparam logic [DQ_W-1:0] LOW_LANE_MASK = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};
    localparam logic [DQ_W-1:0] ALL_LANES     = {DQ_W{1'b1}};

    // Kind of access selected for the coming cycle
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_WORD = 2'd1,
        MODE_BYTE = 2'd2,
        MODE_ID   = 2'd3
    } rd_mode_e;

    // Word stored at a given index: multiplicative hash XOR seed
    function automatic logic [DQ_W-1:0] cell_value(input int unsigned idx,
                                                   input logic [DQ_W-1:0] seed);
        logic [31:0] prod;
        prod = idx * 32'h0000_9E37;
        return prod[DQ_W-1:0] ^ seed;
    endfunction
endpackage

// File: rtl/bw_rom_decode.sv
// Module: bw_rom_decode
// Turns the enables, width select, identifier flag and address into an
// access mode plus the word index, lane pick and identifier pick.
// Assumes ADDR_W >= 2, so that there are address lines above bit 0.
module bw_rom_decode #(
    parameter int ADDR_W = 6
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              word_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    input  logic              id_hv,
    output bw_rom_pkg::rd_mode_e mode,
    output logic [ADDR_W-1:0] word_idx,
    output logic              lane_hi,
    output logic              id_pick
);
    import bw_rom_pkg::*;

    logic upper_clear;

    // Identifier mode is legal only when every line above bit 0 is low
    assign upper_clear = (addr[ADDR_W-1:1] == '0);

    // Mode priority: disabled, then identifier, then word, then byte
    always_comb begin
        if (ce_n || oe_n)
            mode = MODE_OFF;
        else if (id_hv && upper_clear)
            mode = MODE_ID;
        else if (word_sel)
            mode = MODE_WORD;
        else
            mode = MODE_BYTE;
    end

    // Index and lane selects, passed through for the data path
    assign word_idx = addr;
    assign lane_hi  = addr_lsb;
    assign id_pick  = addr[0];

    // The identifier mode is never chosen while a deselecting control is high
    always_comb begin
        if (ce_n || oe_n)
            assert (mode != MODE_ID) else $error("assert_id_needs_enables_R7");
    end
endmodule

// File: rtl/bw_rom_array.sv
// Module: bw_rom_array
// Read-only word array with 2**ADDR_W entries whose contents are computed
// at elaboration from the package content function. Combinational read.
module bw_rom_array #(
    parameter int                ADDR_W   = 6,
    parameter logic [15:0]       ROM_SEED = 16'h5A3C
) (
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [15:0]       rd_word
);
    import bw_rom_pkg::*;

    localparam int WORDS = 1 << ADDR_W;

    logic [DQ_W-1:0] cells [WORDS];

    // One constant cell per index
    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_cell
            assign cells[g] = cell_value(32'(g), ROM_SEED);
        end
    endgenerate

    // Asynchronous read of the selected word
    assign rd_word = cells[rd_idx];
endmodule

// File: rtl/bw_rom_drive.sv
// Module: bw_rom_drive
// Forms the next data value and drive enable from the decoded mode and
// registers both. Undriven bits are forced to zero.
module bw_rom_drive #(
    parameter logic [7:0] MFR_CODE = 8'h01,
    parameter logic [7:0] DEV_CODE = 8'h9D
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bw_rom_pkg::rd_mode_e mode,
    input  logic [15:0]          word,
    input  logic                 lane_hi,
    input  logic                 id_pick,
    output logic [15:0]          dq_out,
    output logic [15:0]          dq_oe
);
    import bw_rom_pkg::*;

    logic [DQ_W-1:0]   nxt_data;
    logic [DQ_W-1:0]   nxt_oe;
    logic [LANE_W-1:0] byte_pick;

    // Byte lane chosen by the extra address line
    assign byte_pick = lane_hi ? word[DQ_W-1:LANE_W] : word[LANE_W-1:0];

    // Next value and enable for each mode
    always_comb begin
        case (mode)
            MODE_WORD: begin
                nxt_oe   = ALL_LANES;
                nxt_data = word;
            end
            MODE_BYTE: begin
                nxt_oe   = LOW_LANE_MASK;
                nxt_data = {{LANE_W{1'b0}}, byte_pick};
            end
            MODE_ID: begin
                nxt_oe   = LOW_LANE_MASK;
                nxt_data = {{LANE_W{1'b0}}, (id_pick ? DEV_CODE : MFR_CODE)};
            end
            default: begin
                nxt_oe   = '0;
                nxt_data = '0;
            end
        endcase
    end

    // Output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= '0;
        end else begin
            dq_out <= nxt_data;
            dq_oe  <= nxt_oe;
        end
    end

    assert_word_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WORD) |=> (dq_oe == ALL_LANES) && (dq_out == $past(word)));

    assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BYTE) |=> (dq_oe == LOW_LANE_MASK) && (dq_out[DQ_W-1:LANE_W] == '0));

    assert_id_odd_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ID) |=> (^dq_out[LANE_W-1:0]) == 1'b1);

    assert_undriven_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_out & ~dq_oe) == '0);
endmodule

// File: rtl/bw_rom_reader.sv
// Module: bw_rom_reader (top)
// Read controller for a byte/word addressable ROM with identifier codes.
// Assumes synchronous active-low reset and ADDR_W >= 2.
module bw_rom_reader #(
    parameter int          ADDR_W   = 6,
    parameter logic [15:0] ROM_SEED = 16'h5A3C,
    parameter logic [7:0]  MFR_CODE = 8'h01,
    parameter logic [7:0]  DEV_CODE = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              word_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    input  logic              id_hv,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe
);
    import bw_rom_pkg::*;

    rd_mode_e          mode;
    logic [ADDR_W-1:0] word_idx;
    logic              lane_hi;
    logic              id_pick;
    logic [DQ_W-1:0]   word;

    bw_rom_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .word_sel (word_sel),
        .addr     (addr),
        .addr_lsb (addr_lsb),
        .id_hv    (id_hv),
        .mode     (mode),
        .word_idx (word_idx),
        .lane_hi  (lane_hi),
        .id_pick  (id_pick)
    );

    bw_rom_array #(.ADDR_W(ADDR_W), .ROM_SEED(ROM_SEED)) u_array (
        .rd_idx  (word_idx),
        .rd_word (word)
    );

    bw_rom_drive #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .word    (word),
        .lane_hi (lane_hi),
        .id_pick (id_pick),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    assert_standby_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (dq_oe == '0));

    assert_disable_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> (dq_oe == '0));

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (dq_oe == '0) && (dq_out == '0));
endmodule

// File: tb/bw_rom_reader_test.sv
// Bench: behavioural reference model, compared once per clock at the falling edge.
module bw_rom_reader_test;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, word_sel, addr_lsb, id_hv;
    logic [AW-1:0] addr;
    logic [15:0]   dq_out, dq_oe;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    logic [15:0] exp_d = 16'h0;
    logic [15:0] exp_e = 16'h0;
    string       exp_tag = "R1";
    bit          exp_id  = 1'b0;

    always #2 clk = ~clk;

    bw_rom_reader #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .word_sel(word_sel),
        .addr(addr), .addr_lsb(addr_lsb), .id_hv(id_hv),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Content rule from R5
    function automatic logic [15:0] ref_word(int a);
        int p;
        p = (a * 40503) % 65536;
        return 16'(p) ^ 16'h5A3C;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model of the value registered at the next edge
    task automatic model(output logic [15:0] d, output logic [15:0] e,
                         output string tag, output bit isid);
        logic [15:0] w;
        isid = 1'b0;
        w = ref_word(int'(addr));
        if (!rst_n) begin d = 0; e = 0; tag = "R1"; end
        else if (ce_n) begin d = 0; e = 0; tag = "R2"; end
        else if (oe_n) begin d = 0; e = 0; tag = "R3"; end
        else if (id_hv && (addr >> 1) == 0) begin
            e = 16'h00FF; isid = 1'b1;
            if (addr[0]) begin d = 16'h009D; tag = "R8"; end
            else begin d = 16'h0001; tag = "R7"; end
        end else begin
            tag = id_hv ? "R10" : (word_sel ? "R5" : "R6");
            if (word_sel) begin d = w; e = 16'hFFFF; end
            else begin d = {8'h00, (addr_lsb ? w[15:8] : w[7:0])}; e = 16'h00FF; end
        end
    endtask

    // One cycle: check previous expectation, drive new inputs, check hold (R4)
    task automatic step(bit r, bit ce, bit oe, bit ws, int a, bit lsb, bit hv);
        string t;
        bit    idf;
        logic [15:0] d, e;
        @(negedge clk);
        chk(exp_tag, dq_out, exp_d);
        chk(exp_tag, dq_oe, exp_e);
        chk("R11", dq_out & ~dq_oe, 16'h0);
        if (exp_id) chk("R9", {15'h0, ^dq_out[7:0]}, 16'h1);
        rst_n = r; ce_n = ce; oe_n = oe; word_sel = ws;
        addr = AW'(a); addr_lsb = lsb; id_hv = hv;
        #1;
        chk("R4", dq_out, exp_d);
        chk("R4", dq_oe, exp_e);
        model(d, e, t, idf);
        exp_d = d; exp_e = e; exp_tag = t; exp_id = idf;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lfsr;
        rst_n = 0; ce_n = 0; oe_n = 0; word_sel = 1; addr = 0; addr_lsb = 0; id_hv = 0;
        // R1: reset with enables active must still clear
        repeat (3) step(0, 0, 0, 1, 5, 0, 0);
        // R2: standby with oe both ways, several addresses
        step(1, 1, 0, 1, 3, 0, 0);
        step(1, 1, 1, 0, 9, 1, 0);
        step(1, 1, 0, 1, 0, 0, 1);
        // R3: output disable
        step(1, 0, 1, 1, 7, 0, 0);
        step(1, 0, 1, 0, 1, 1, 1);
        // R5: word reads incl. boundaries, back to back
        step(1, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, (1 << AW) - 1, 0, 0);
        step(1, 0, 0, 1, 21, 1, 0);
        // R6: byte reads both lanes
        step(1, 0, 0, 0, 21, 0, 0);
        step(1, 0, 0, 0, 21, 1, 0);
        step(1, 0, 0, 0, (1 << AW) - 1, 1, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        // R7 / R8 / R9: identifier codes in both width modes, lsb ignored
        step(1, 0, 0, 1, 0, 0, 1);
        step(1, 0, 0, 1, 1, 1, 1);
        step(1, 0, 0, 0, 0, 1, 1);
        step(1, 0, 0, 0, 1, 0, 1);
        // R10: an upper line set cancels the identifier request
        step(1, 0, 0, 1, 2, 0, 1);
        step(1, 0, 0, 0, 3, 1, 1);
        step(1, 0, 0, 1, 1 << (AW - 1), 0, 1);
        // R2 after identifier: standby wins over the flag
        step(1, 1, 0, 1, 1, 0, 1);
        // Random mix biased toward identifier reads
        lfsr = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            int a;
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFF_FFFF;
            a = (lfsr >> 4) % (1 << AW);
            if (((lfsr >> 12) & 3) == 0) a = a & 1;
            step(((lfsr >> 20) % 31) != 0, ((lfsr >> 21) & 7) == 0, ((lfsr >> 24) & 7) == 0,
                 (lfsr >> 27) & 1, a, (lfsr >> 28) & 1, (lfsr >> 13) & 1);
        end
        step(1, 1, 1, 1, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule